// File: doc/BRIEF.md
# Start-of-Frame Frame Number Capture Register

This block sits inside a full-speed USB device controller. Each time the token decoder reports a valid start-of-frame token, the block latches the 11-bit frame number that the token carries. Software reads the number through two read-only views on a byte-wide register bus. The low view holds the eight least significant bits. The high view holds the three most significant bits, together with the start-of-frame interrupt request and mask flags.

The request flag is set by hardware on every start-of-frame. Software clears it by writing a one to it. The mask flag is active high: a one disables the interrupt. A level interrupt output follows the request while the mask is clear. Both halves of the frame number are loaded on the same clock edge, so the two views always describe one frame. Bits of the high view that belong to other endpoint logic read as zero here. The reserved upper bits of a wider bus fall outside this byte-wide interface.

Top module: `sof_frame_capture`

## Requirements
- R1: After reset, the low view reads 0x00, the high view reads 0x40 (mask set, request clear, frame bits zero), and `sof_irq` is 0.
- R2: One clock edge after `sof_valid` is high, the low view (`reg_sel`=0) reads bits 7:0 of the `sof_frame` value presented with that strobe.
- R3: One clock edge after `sof_valid` is high, bits 2:0 of the high view (`reg_sel`=1) read bits 10:8 of that frame value, and bits 5:3 read 0.
- R4: Writes to the low view have no effect, and the data written to bits 2:0 of the high view has no effect. Without a start-of-frame strobe, the frame number holds.
- R5: A start-of-frame strobe sets the request flag, which reads at bit 7 of the high view.
- R6: A write to the high view with bit 7 set clears the request flag. A write with bit 7 clear leaves the flag unchanged.
- R7: Bit 6 of the high view is the mask flag. It takes the value of write data bit 6 on every write to the high view. `sof_irq` is 1 exactly when the request is 1 and the mask is 0.
- R8: When a start-of-frame strobe and a request-clearing write fall in the same cycle, the request flag ends up set.
- R9: When `reg_rd` is low, `reg_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_valid | input | 1 | Single-cycle strobe for a decoded start-of-frame token |
| sof_frame | input | 11 | Frame number carried by the token, valid with the strobe |
| reg_sel | input | 1 | Register select: 0 is the low view, 1 is the high view |
| reg_rd | input | 1 | Read enable; read data is combinational |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| sof_irq | output | 1 | Level start-of-frame interrupt |

## Verification
The assertions assume that `sof_frame` carries a meaningful value only while `sof_valid` is high. They also assume that a write strobe lasts exactly one cycle, so each write counts as one event. The stimulus drives every input on the falling clock edge and keeps each strobe to one cycle. Frame values are swept across the full 11-bit range. A strobe and a write share a cycle only in the deliberate collision case.

// File: rtl/sof_cap_pkg.sv
package sof_cap_pkg;
  localparam int REQ_BIT  = 7;
  localparam int MASK_BIT = 6;

  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } reg_sel_e;

  // next request flag: a new frame outranks a clearing write
  function automatic logic req_next(input logic req, input logic sof, input logic clr);
    return sof | (req & ~clr);
  endfunction

  function automatic logic irq_level(input logic req, input logic mask);
    return req & ~mask;
  endfunction
endpackage

// File: rtl/sof_frame_latch.sv
module sof_frame_latch #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_valid,
  input  logic [FRAME_W-1:0] sof_frame,
  output logic [FRAME_W-1:0] frame_q
);
  // one register for the whole number: both views change on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frame_q <= '0;
    else if (sof_valid) frame_q <= sof_frame;
  end

  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid |=> frame_q == $past(sof_frame)); // R2
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_valid |=> $stable(frame_q)); // R4
endmodule

// File: rtl/sof_irq_ctrl.sv
module sof_irq_ctrl
  import sof_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sof_valid,
  input  logic hi_wr,
  input  logic wr_req_bit,
  input  logic wr_mask_bit,
  output logic req_q,
  output logic mask_q,
  output logic irq
);
  logic clr_req;
  assign clr_req = hi_wr & wr_req_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      req_q <= req_next(req_q, sof_valid, clr_req);
      if (hi_wr) mask_q <= wr_mask_bit;
    end
  end

  assign irq = irq_level(req_q, mask_q);

  AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid |=> req_q); // R8
  AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !sof_valid) |=> !req_q); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !sof_valid) |=> $stable(req_q)); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(mask_q)); // R7
endmodule

// File: rtl/sof_reg_readmux.sv
module sof_reg_readmux
  import sof_cap_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int DATA_W  = 8
) (
  input  logic               rd,
  input  reg_sel_e           sel,
  input  logic [FRAME_W-1:0] frame,
  input  logic               req,
  input  logic               mask,
  output logic [DATA_W-1:0]  rdata
);
  localparam int HI_W = FRAME_W - DATA_W; // must leave room below MASK_BIT

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (sel == SEL_LOW) begin
        rdata = frame[DATA_W-1:0];
      end else begin
        rdata[HI_W-1:0] = frame[FRAME_W-1:DATA_W];
        rdata[MASK_BIT] = mask;
        rdata[REQ_BIT]  = req;
      end
    end
  end
endmodule

// File: rtl/sof_frame_capture.sv
module sof_frame_capture
  import sof_cap_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_valid,
  input  logic [FRAME_W-1:0] sof_frame,
  input  logic               reg_sel,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               sof_irq
);
  reg_sel_e           sel;
  logic               hi_wr;
  logic [FRAME_W-1:0] frame_q;
  logic               req_q;
  logic               mask_q;

  assign sel   = reg_sel_e'(reg_sel);
  assign hi_wr = reg_wr & (sel == SEL_HIGH);

  sof_frame_latch #(.FRAME_W(FRAME_W)) latch_i (
    .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid),
    .sof_frame(sof_frame), .frame_q(frame_q)
  );

  sof_irq_ctrl irq_i (
    .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid), .hi_wr(hi_wr),
    .wr_req_bit(reg_wdata[REQ_BIT]), .wr_mask_bit(reg_wdata[MASK_BIT]),
    .req_q(req_q), .mask_q(mask_q), .irq(sof_irq)
  );

  sof_reg_readmux #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) mux_i (
    .rd(reg_rd), .sel(sel), .frame(frame_q), .req(req_q), .mask(mask_q),
    .rdata(reg_rdata)
  );

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0); // R9
  AST_IRQ_NEEDS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_irq) |-> ($past(sof_valid) || $past(hi_wr))); // R7
endmodule

// File: tb/sof_frame_capture_tb_top.sv
`timescale 1ns/1ps
module sof_frame_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof_valid = 1'b0;
  logic [10:0] sof_frame = '0;
  logic        reg_sel = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        sof_irq;

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_frame = '0;
  logic        exp_req = 1'b0;
  logic        exp_mask = 1'b1;

  always #2 clk = ~clk;

  sof_frame_capture dut_i (
    .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid), .sof_frame(sof_frame),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sof_irq(sof_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hi_view();
    return {exp_req, exp_mask, 3'b000, exp_frame[10:8]};
  endfunction

  // one cycle of stimulus, launched and retired on falling edges
  task automatic step(input logic sof, input logic [10:0] f, input logic wr,
                      input logic sel, input logic [7:0] wd);
    @(negedge clk);
    sof_valid = sof; sof_frame = f; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(negedge clk);
    sof_valid = 1'b0; reg_wr = 1'b0;
    if (sof) begin exp_frame = f; end
    if (wr && sel) begin
      exp_mask = wd[6];
      if (wd[7]) exp_req = 1'b0;
    end
    if (sof) exp_req = 1'b1;
  endtask

  task automatic read_both(input string tlo, input string thi);
    reg_rd = 1'b1; reg_sel = 1'b0; #0.5;
    check(tlo, reg_rdata, exp_frame[7:0]);
    reg_sel = 1'b1; #0.5;
    check(thi, reg_rdata, hi_view());
    reg_rd = 1'b0; #0.5;
    check("R7 irq", {7'b0, sof_irq}, {7'b0, exp_req & ~exp_mask});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    read_both("R1 low reset", "R1 high reset");
    check("R1 high literal", {exp_req, exp_mask, 6'b0}, 8'h40);
    rst_n = 1'b1;
    @(negedge clk);
    read_both("R1 low after release", "R1 high after release");

    // full frame sweep with periodic mask toggles and request clears
    for (int f = 0; f < 2048; f++) begin
      step(1'b1, 11'(f), 1'b0, 1'b0, 8'h00);
      read_both("R2 low frame", "R3 R5 high frame");
      if (f % 256 == 100) begin
        step(1'b0, '0, 1'b1, 1'b1, {1'b1, exp_mask, 6'b0}); // R6 clear
        read_both("R6 low", "R6 high after clear");
      end
      if (f % 512 == 200) begin
        step(1'b0, '0, 1'b1, 1'b1, {1'b0, ~exp_mask, 6'b0}); // R6 write-0, R7 mask
        read_both("R7 low", "R6 R7 high after mask write");
      end
    end

    // R4: frame fields ignore writes
    step(1'b1, 11'h5A3, 1'b0, 1'b0, 8'h00);
    step(1'b0, '0, 1'b1, 1'b0, 8'hFF);
    read_both("R4 low after low write", "R4 high after low write");
    step(1'b0, '0, 1'b1, 1'b1, {1'b0, exp_mask, 6'b111111});
    read_both("R4 low after high write", "R4 high after high write");

    // R8: strobe and clearing write collide
    step(1'b0, '0, 1'b1, 1'b1, 8'h80);
    read_both("R8 low pre", "R8 high pre (cleared)");
    step(1'b1, 11'h2C7, 1'b1, 1'b1, 8'h80);
    read_both("R8 low", "R8 request survives");
    check("R8 literal", {7'b0, exp_req}, 8'h01);

    // R7: unmasked interrupt asserted then cleared
    step(1'b0, '0, 1'b1, 1'b0 ^ 1'b1, 8'h00);
    read_both("R7 low", "R7 high unmasked");
    check("R7 irq high", {7'b0, sof_irq}, 8'h01);
    step(1'b0, '0, 1'b1, 1'b1, 8'h80);
    check("R7 irq low after clear", {7'b0, sof_irq}, 8'h00);

    // R9: idle read port
    reg_rd = 1'b0; reg_sel = 1'b1; #0.5;
    check("R9 idle high", reg_rdata, 8'h00);
    reg_sel = 1'b0; #0.5;
    check("R9 idle low", reg_rdata, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule